// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer. It counts ticks from a chosen time base. If software does not clear it before the programmed number of ticks, it raises a one-cycle reset request.

The time base is chosen by static configuration pins:
- the system clock divided by four, made by a free-running 2-bit prescaler; or
- a slow sub-clock tick, itself picked from two enable inputs: an internal low-speed oscillator tick or a crystal oscillator tick.

An 8-bit control register sits on a plain write/read port and holds three fields:
- an idle-mode system-clock enable;
- a 3-bit timeout select, giving 2^8 to 2^15 ticks;
- a 4-bit enable key.

Exactly one key pattern, 1010, stops the watchdog. Every other pattern lets it run. The CPU clears the counter through a one-cycle clear strobe or by any register write. The reset request drives the chip's reset sequencer, which lies outside this block.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the control register reads 0x70 (idle enable 0, select 111, key 0000), the watchdog runs, and the reset request is low.
- R2: All eight control bits are writable and readable; `reg_rdata` shows the written byte from the cycle after a write.
- R3: Control bit 7 drives `idle_fsys_on` directly.
- R4: Control bits [6:4] hold select s, and the timeout is N = 2^(8+s) ticks after the last clear. `wdt_rst_req` is high for exactly one cycle, in the cycle after the clock edge that takes the Nth tick.
- R5: Key bits [3:0] equal to 1010 disable the watchdog and hold the counter at zero, so no request is raised. Any other key value, including 1011, enables counting.
- R6: A high `sw_clr` or a register write clears the counter at that edge, and the next N ticks start from zero.
- R7: After a timeout the counter restarts from zero, so the next request follows N ticks later.
- R8: With `cfg_src_div4`=1 one tick occurs every fourth system clock. With it at 0, the tick is `lxt_tick` when `cfg_sub_xtal`=1 and `lirc_tick` otherwise.
- R9: The counter advances only on edges where the selected tick is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_src_div4 | input | 1 | Static: 1 selects system clock/4, 0 selects the sub-clock |
| cfg_sub_xtal | input | 1 | Static: 1 selects the crystal tick, 0 the internal low-speed tick |
| lirc_tick | input | 1 | Internal low-speed oscillator tick enable |
| lxt_tick | input | 1 | Crystal oscillator tick enable |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| sw_clr | input | 1 | One-cycle counter clear from software |
| idle_fsys_on | output | 1 | Idle-mode system clock enable (control bit 7) |
| wdt_rst_req | output | 1 | One-cycle reset request on timeout |

## Verification
The bench builds the block with its default parameters: base exponent 8, a 3-bit select and a 2-bit prescaler. With these values even the longest timeout, 32768 ticks, fits in the run, so the exact request cycle is measured for all eight select codes and compared with a bench function. With the sub-tick held high every clock, tick counts equal clock counts. Random tick gating on the shortest timeout then shows that only enabled edges count, and the divide-by-four path is checked as a 1024-cycle distance between consecutive requests.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int SEL_W  = 3;
  localparam int KEY_W  = 4;
  localparam int CTRL_W = 1 + SEL_W + KEY_W;

  typedef struct packed {
    logic             idle_on;
    logic [SEL_W-1:0] tsel;
    logic [KEY_W-1:0] key;
  } wdt_ctrl_t;
endpackage

// File: rtl/wdt_tick_src.sv
module wdt_tick_src #(
  parameter int PRE_W = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic use_div,
  input  logic use_xtal,
  input  logic lirc_tick,
  input  logic lxt_tick,
  output logic tick
);
  logic [PRE_W-1:0] pre_q;
  logic             div_tick;
  logic             sub_tick;

  always_ff @(posedge clk) begin
    if (rst) pre_q <= '0;
    else     pre_q <= pre_q + 1'b1;
  end

  assign div_tick = &pre_q;
  assign sub_tick = use_xtal ? lxt_tick : lirc_tick;
  assign tick     = use_div ? div_tick : sub_tick;

  // R8: the divided tick never stays high on two edges in a row
  assert_div_gap_R8: assert property (@(posedge clk) disable iff (rst)
    div_tick |=> !div_tick);
endmodule

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
  import wdt_pkg::*;
#(
  parameter logic [KEY_W-1:0]  OFF_KEY  = 4'b1010,
  parameter logic [CTRL_W-1:0] RST_CTRL = 8'h70
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [CTRL_W-1:0] wdata,
  output wdt_ctrl_t         ctrl,
  output logic              run
);
  always_ff @(posedge clk) begin
    if (rst)     ctrl <= wdt_ctrl_t'(RST_CTRL);
    else if (wr) ctrl <= wdt_ctrl_t'(wdata);
  end

  assign run = (ctrl.key != OFF_KEY);

  assert_wr_readback_R2: assert property (@(posedge clk) disable iff (rst)
    wr |=> (ctrl == wdt_ctrl_t'($past(wdata))));
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(ctrl));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int BASE_LOG2 = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             run,
  input  logic             clr,
  input  logic [SEL_W-1:0] tsel,
  output logic             expire
);
  localparam int MAX_SEL = (1 << SEL_W) - 1;
  localparam int CNT_W   = BASE_LOG2 + MAX_SEL;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_val;

  assign last_val = {CNT_W{1'b1}} >> (CNT_W'(MAX_SEL) - CNT_W'(tsel));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      expire <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (clr || !run) begin
        cnt_q <= '0;
      end else if (tick) begin
        if (cnt_q >= last_val) begin
          cnt_q  <= '0;
          expire <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assert_pulse_single_R4: assert property (@(posedge clk) disable iff (rst)
    expire |=> !expire);
  assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!expire && cnt_q == '0));
  assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_q == '0 && !expire));
  assert_restart_R7: assert property (@(posedge clk) disable iff (rst)
    expire |-> (cnt_q == '0));
  assert_tick_gate_R9: assert property (@(posedge clk) disable iff (rst)
    (!tick && !clr && run) |=> ($stable(cnt_q) && !expire));
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import wdt_pkg::*;
#(
  parameter int                BASE_LOG2 = 8,
  parameter int                PRE_W     = 2,
  parameter logic [KEY_W-1:0]  OFF_KEY   = 4'b1010,
  parameter logic [CTRL_W-1:0] RST_CTRL  = 8'h70
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_src_div4,
  input  logic              cfg_sub_xtal,
  input  logic              lirc_tick,
  input  logic              lxt_tick,
  input  logic              reg_wr,
  input  logic [CTRL_W-1:0] reg_wdata,
  output logic [CTRL_W-1:0] reg_rdata,
  input  logic              sw_clr,
  output logic              idle_fsys_on,
  output logic              wdt_rst_req
);
  wdt_ctrl_t ctrl;
  logic      run;
  logic      tick;

  wdt_tick_src #(.PRE_W(PRE_W)) u_src (
    .clk(clk), .rst(rst), .use_div(cfg_src_div4), .use_xtal(cfg_sub_xtal),
    .lirc_tick(lirc_tick), .lxt_tick(lxt_tick), .tick(tick)
  );

  wdt_ctrl_reg #(.OFF_KEY(OFF_KEY), .RST_CTRL(RST_CTRL)) u_reg (
    .clk(clk), .rst(rst), .wr(reg_wr), .wdata(reg_wdata),
    .ctrl(ctrl), .run(run)
  );

  wdt_counter #(.BASE_LOG2(BASE_LOG2)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .run(run),
    .clr(sw_clr | reg_wr), .tsel(ctrl.tsel), .expire(wdt_rst_req)
  );

  assign reg_rdata    = ctrl;
  assign idle_fsys_on = ctrl.idle_on;

  assert_idle_bit_R3: assert property (@(posedge clk) disable iff (rst)
    reg_wr |=> (idle_fsys_on == $past(reg_wdata[CTRL_W-1])));
endmodule

// File: tb/keyed_wdt_tb.sv
module keyed_wdt_tb;
  localparam int TCLK = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_src_div4 = 1'b0, cfg_sub_xtal = 1'b0;
  logic       lirc_tick = 1'b1, lxt_tick = 1'b0;
  logic       reg_wr = 1'b0, sw_clr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       idle_fsys_on, wdt_rst_req;

  int checks = 0;
  int errors = 0;

  always #(TCLK/2) clk = ~clk;

  keyed_wdt u_dut (
    .clk(clk), .rst(rst), .cfg_src_div4(cfg_src_div4), .cfg_sub_xtal(cfg_sub_xtal),
    .lirc_tick(lirc_tick), .lxt_tick(lxt_tick), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sw_clr(sw_clr),
    .idle_fsys_on(idle_fsys_on), .wdt_rst_req(wdt_rst_req)
  );

  function automatic int exp_ticks(input int s);
    return 1 << (8 + s);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // counts edges until the request is seen; returns limit+1 if never
  task automatic wait_req(input int limit, output int n);
    n = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      n++;
      if (wdt_rst_req) return;
    end
    n = limit + 1;
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(TCLK * 190000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 rdata", reg_rdata, 8'h70);
    chk("R1 req", wdt_rst_req, 0);
    chk("R3 idle reset", idle_fsys_on, 0);

    // R2/R3 random readback
    for (int k = 0; k < 16; k++) begin
      logic [7:0] d;
      d = 8'($urandom);
      wr_reg(d);
      chk("R2 readback", reg_rdata, d);
      chk("R3 idle bit", idle_fsys_on, d[7]);
    end

    // R4/R7 exact timeout for every select, ticks every cycle
    for (int s = 0; s < 8; s++) begin
      wr_reg({1'b0, 3'(s), 4'b0011});
      wait_req(exp_ticks(s) + 4, n);
      chk("R4 timeout", n, exp_ticks(s));
      @(negedge clk);
      chk("R4 one cycle", wdt_rst_req, 0);
      if (s < 2) begin
        wait_req(exp_ticks(s) + 4, n);
        chk("R7 restart", n, exp_ticks(s) - 1);
      end
    end

    // R5 disable key, then 1011 keeps it enabled
    wr_reg(8'h0A);
    wait_req(700, n);
    chk("R5 disabled", n, 701);
    wr_reg(8'h8A);
    wait_req(700, n);
    chk("R5 disabled idle set", n, 701);
    wr_reg(8'h0B);
    wait_req(300, n);
    chk("R5 1011 runs", n, 256);

    // R6 software clear mid-count
    wr_reg(8'h05);
    repeat (200) @(negedge clk);
    sw_clr = 1'b1;
    @(negedge clk);
    sw_clr = 1'b0;
    wait_req(300, n);
    chk("R6 sw clear", n, 256);
    // R6 write clear mid-count
    repeat (150) @(negedge clk);
    wr_reg(8'h05);
    wait_req(300, n);
    chk("R6 write clear", n, 256);

    // R9 random tick gating
    wr_reg(8'h01);
    begin
      int ticks = 0;
      int seen = 0;
      for (int i = 0; i < 2000 && !seen; i++) begin
        logic t;
        t = 1'($urandom);
        lirc_tick = t;
        @(negedge clk);
        if (t) ticks++;
        if (wdt_rst_req) seen = 1;
      end
      chk("R9 gated ticks", ticks, 256);
    end
    lirc_tick = 1'b1;

    // R8 crystal select ignores the internal tick
    cfg_sub_xtal = 1'b1; lxt_tick = 1'b0;
    wr_reg(8'h01);
    wait_req(600, n);
    chk("R8 xtal idle", n, 601);
    lxt_tick = 1'b1;
    wr_reg(8'h01);
    wait_req(300, n);
    chk("R8 xtal runs", n, 256);

    // R8 divide-by-four spacing
    cfg_src_div4 = 1'b1;
    wr_reg(8'h01);
    wait_req(1100, n);
    wait_req(1100, n);
    chk("R8 div4 period", n, 1024);

    finish_run();
  end
endmodule